// File: doc/BRIEF.md
# Multi-mode serial command/data receiver

This block is the host-facing receiver of a display controller. A host writes bytes to it over a clocked serial link, and the block hands each finished byte to the core. Every byte comes with a single-cycle strobe and a flag that says whether the byte is display data or a command. Two static select inputs choose one of three framings, and all three share one shift register:

- plain three-wire SPI, where a software length instruction marks the display-data bytes;
- four-wire SPI, where a data/command pin marks each byte;
- a three-wire serial format in which each byte is preceded by its own data/command bit.

The serial pins are oversampled by the system clock through two-flop synchronisers, so the system clock must run several times faster than the serial clock.

After a read-status command, the block shifts a status byte out on a separate push-pull output. The output comes with its own enable, which marks when it would be driven. The fourth select code belongs to a two-wire bus that lives elsewhere, and for that code this block stays silent.

Top module: `serial_cmd_rx`

## Requirements
- R1: With select code 2'b10 the block emits no byte strobes and keeps `sdo_oe` low, whatever the serial pins do.
- R2: While chip enable (`csn_pin`, active low) is high, serial clock pulses are ignored: no byte is assembled and no strobe is produced. A falling chip enable starts a fresh byte.
- R3: Data is sampled on rising serial-clock edges, most significant bit first. Each completed byte gives exactly one `byte_valid` pulse, one system clock wide, with the byte on `byte_data`.
- R4: With select 2'b01 (four-wire SPI), `byte_is_data` equals the level of `dc_pin` at the byte's eighth rising edge: 1 means display data, 0 means command.
- R5: With select 2'b11, the first rising edge of each frame captures a data/command bit (1 = display data) and the next eight capture the byte. While chip enable stays low, frames follow back to back.
- R6: With select 2'b00 (three-wire SPI), the command byte 8'h2D (parameter `LEN_OP`) followed by a length byte N makes exactly the next N bytes display data, and the byte after them is a command. The opcode and the length byte are both reported as commands. All other bytes are commands.
- R7: In select 2'b00, a length byte of 0 is treated as 1.
- R8: If chip enable rises before the final rising edge of a byte has been taken, that partial byte produces no strobe and earlier bytes stay valid. The next byte is treated as a command, which cancels any outstanding data-length count. This includes a chip-enable rise in the same sample as the final edge.
- R9: After a command byte equal to 8'h3C (parameter `RD_OP`), the block leaves receive mode. Each of the next eight falling serial-clock edges drives one bit of `status_in` (MSB first) on `sdo_out` with `sdo_oe` high. `sdo_oe` drops after the eighth rising edge. No strobes are produced during this read.
- R10: A synchronous reset aborts any byte in progress. If chip enable is low after reset, the next rising edge is the first bit of a new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Static framing select (00 SPI3, 01 SPI4, 10 idle, 11 nine-bit) |
| csn_pin | input | 1 | Chip enable, active low |
| sclk_pin | input | 1 | Serial clock |
| sdin_pin | input | 1 | Serial data in |
| dc_pin | input | 1 | Data/command pin, used with select 01 |
| status_in | input | 8 | Status byte to return on a read-status command |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Received byte |
| byte_is_data | output | 1 | 1 = display data, 0 = command |
| sdo_out | output | 1 | Read-back serial data |
| sdo_oe | output | 1 | Read-back drive enable |

## Verification
Two functions can fall in the same system-clock sample: a byte's final rising serial edge and the chip-enable release that aborts the transfer. The bench provokes this by raising the serial clock and chip enable together on the eighth bit while a data-length count is outstanding. The case passes if no strobe appears for that byte and the next byte arrives flagged as a command. A second overlap is also covered: a data byte whose value equals the read-status opcode must stay data, and must not start a read.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    MODE_SPI3 = 2'b00,
    MODE_SPI4 = 2'b01,
    MODE_BUS  = 2'b10,
    MODE_SER9 = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/srx_pin_sync.sv
module srx_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= RST_VAL;
          else     stage[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= RST_VAL;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import serial_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  rx_mode_e      mode,
  input  logic          cs_idle,
  input  logic          rx_rise,
  input  logic          sdin,
  input  logic          dcpin,
  output logic          done,
  output logic [DW-1:0] byte_o,
  output logic          dc_o,
  output logic          abort
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST_SPI = CW'(DW - 1);
  localparam logic [CW-1:0] LAST_SER = CW'(DW);

  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          dcb;
  logic [CW-1:0] last;

  assign last = (mode == MODE_SER9) ? LAST_SER : LAST_SPI;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sh     <= '0;
      dcb    <= 1'b0;
      done   <= 1'b0;
      byte_o <= '0;
      dc_o   <= 1'b0;
      abort  <= 1'b0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      if (cs_idle) begin
        if (cnt != '0) abort <= 1'b1;
        cnt <= '0;
      end else if (rx_rise) begin
        if (mode == MODE_SER9 && cnt == '0) dcb <= sdin;
        else sh <= {sh[DW-2:0], sdin};
        if (cnt == last) begin
          cnt    <= '0;
          done   <= 1'b1;
          byte_o <= {sh[DW-2:0], sdin};
          dc_o   <= (mode == MODE_SER9) ? dcb : dcpin;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/srx_classifier.sv
module srx_classifier
  import serial_rx_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] LEN_OP = 8'h2D,
  parameter logic [DW-1:0] RD_OP  = 8'h3C
) (
  input  logic          clk,
  input  logic          rst,
  input  rx_mode_e      mode,
  input  logic          done,
  input  logic [DW-1:0] byte_i,
  input  logic          dc_i,
  input  logic          abort,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          is_data,
  output logic          rd_start
);
  logic [DW-1:0] rem;
  logic          expect_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid      <= 1'b0;
      data       <= '0;
      is_data    <= 1'b0;
      rd_start   <= 1'b0;
      rem        <= '0;
      expect_len <= 1'b0;
    end else begin
      valid    <= 1'b0;
      rd_start <= 1'b0;
      if (done) begin
        valid <= 1'b1;
        data  <= byte_i;
        if (mode == MODE_SPI3) begin
          if (rem != '0) begin
            is_data <= 1'b1;
            rem     <= rem - 1'b1;
          end else if (expect_len) begin
            is_data    <= 1'b0;
            expect_len <= 1'b0;
            rem        <= (byte_i == '0) ? DW'(1) : byte_i;
          end else begin
            is_data    <= 1'b0;
            expect_len <= (byte_i == LEN_OP);
            rd_start   <= (byte_i == RD_OP);
          end
        end else begin
          is_data    <= dc_i;
          rd_start   <= !dc_i && (byte_i == RD_OP);
          rem        <= '0;
          expect_len <= 1'b0;
        end
      end else if (abort || mode != MODE_SPI3) begin
        rem        <= '0;
        expect_len <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srx_readback.sv
module srx_readback #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_idle,
  input  logic          rd_start,
  input  logic [DW-1:0] status_i,
  input  logic          fall,
  input  logic          rise,
  output logic          busy,
  output logic          sdo,
  output logic          oe
);
  localparam int RC = $clog2(DW);
  localparam logic [RC-1:0] LAST = RC'(DW - 1);

  logic [DW-1:0] sh;
  logic [RC-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sdo  <= 1'b0;
      oe   <= 1'b0;
      sh   <= '0;
      rcnt <= '0;
    end else if (cs_idle) begin
      busy <= 1'b0;
      oe   <= 1'b0;
      rcnt <= '0;
    end else if (rd_start) begin
      busy <= 1'b1;
      sh   <= status_i;
      rcnt <= '0;
      oe   <= 1'b0;
    end else if (busy) begin
      if (fall) begin
        sdo <= sh[DW-1];
        sh  <= {sh[DW-2:0], 1'b0};
        oe  <= 1'b1;
      end else if (rise && oe) begin
        if (rcnt == LAST) begin
          busy <= 1'b0;
          oe   <= 1'b0;
          rcnt <= '0;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_rx_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-1:0] LEN_OP = 8'h2D,
  parameter logic [DW-1:0] RD_OP  = 8'h3C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic          csn_pin,
  input  logic          sclk_pin,
  input  logic          sdin_pin,
  input  logic          dc_pin,
  input  logic [DW-1:0] status_in,
  output logic          byte_valid,
  output logic [DW-1:0] byte_data,
  output logic          byte_is_data,
  output logic          sdo_out,
  output logic          sdo_oe
);
  rx_mode_e mode;
  logic [3:0] pins_s;
  logic csn_s, sclk_s, sdin_s, dc_s, sclk_d;
  logic sclk_rise, sclk_fall, cs_idle, rd_busy;
  logic f_done, f_dc, f_abort, rd_start;
  logic [DW-1:0] f_byte;

  assign mode = rx_mode_e'(mode_sel);

  srx_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk(clk), .rst(rst),
    .din({dc_pin, sdin_pin, sclk_pin, csn_pin}),
    .dout(pins_s)
  );
  assign {dc_s, sdin_s, sclk_s, csn_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_idle   = csn_s | (mode == MODE_BUS);

  srx_framer #(.DW(DW)) u_framer (
    .clk(clk), .rst(rst), .mode(mode), .cs_idle(cs_idle),
    .rx_rise(sclk_rise & ~rd_busy), .sdin(sdin_s), .dcpin(dc_s),
    .done(f_done), .byte_o(f_byte), .dc_o(f_dc), .abort(f_abort)
  );

  srx_classifier #(.DW(DW), .LEN_OP(LEN_OP), .RD_OP(RD_OP)) u_class (
    .clk(clk), .rst(rst), .mode(mode), .done(f_done), .byte_i(f_byte),
    .dc_i(f_dc), .abort(f_abort), .valid(byte_valid), .data(byte_data),
    .is_data(byte_is_data), .rd_start(rd_start)
  );

  srx_readback #(.DW(DW)) u_rdbk (
    .clk(clk), .rst(rst), .cs_idle(cs_idle), .rd_start(rd_start),
    .status_i(status_in), .fall(sclk_fall), .rise(sclk_rise),
    .busy(rd_busy), .sdo(sdo_out), .oe(sdo_oe)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_sel,
  input logic       csn_pin,
  input logic       byte_valid,
  input logic       sdo_oe
);
  // R1: the bus-reserved select code keeps the block silent
  a_r1_bus_code_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10 && $past(mode_sel) == 2'b10 && $past(mode_sel, 2) == 2'b10)
      |-> (!byte_valid && !sdo_oe));

  // R2: chip enable held high long enough gives no strobe and no drive
  a_r2_cs_high_quiet: assert property (@(posedge clk) disable iff (rst)
    (csn_pin && $past(csn_pin) && $past(csn_pin, 2) && $past(csn_pin, 3) && $past(csn_pin, 4))
      |-> (!byte_valid && !sdo_oe));

  // R3: each byte strobe lasts one cycle
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  // R9: no byte strobe while the read-back output is driven
  a_r9_read_no_strobe: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !byte_valid);
endmodule

bind serial_cmd_rx srx_checker u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .csn_pin(csn_pin),
  .byte_valid(byte_valid), .sdo_oe(sdo_oe)
);

// File: tb/serial_cmd_rx_tb.sv
module serial_cmd_rx_tb;
  localparam logic [7:0] LEN_OP = 8'h2D;
  localparam logic [7:0] RD_OP  = 8'h3C;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic csn = 1'b1, sclk = 1'b0, sdin = 1'b0, dc = 1'b0;
  logic [7:0] status = 8'h00;
  logic byte_valid, byte_is_data, sdo_out, sdo_oe;
  logic [7:0] byte_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];
  logic m_len = 1'b0;
  int m_rem = 0;

  always #5 clk = ~clk;

  serial_cmd_rx u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .csn_pin(csn), .sclk_pin(sclk),
    .sdin_pin(sdin), .dc_pin(dc), .status_in(status), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_is_data(byte_is_data), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
  );

  always @(negedge clk) if (byte_valid) got_q.push_back({byte_is_data, byte_data});

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic v);
    sdin = v; wclk(HP); sclk = 1'b1; wclk(HP); sclk = 1'b0;
  endtask

  task automatic cs_lo; csn = 1'b0; wclk(HP); endtask
  task automatic cs_hi; wclk(HP); csn = 1'b1; wclk(2 * HP); endtask

  task automatic send_raw(input logic [7:0] b, input logic d);
    dc = d;
    if (mode_sel == 2'b11) bit_out(d);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  // bench model of the three-wire SPI length rule (R6, R7)
  task automatic model3(input logic [7:0] b);
    if (m_rem > 0) begin exp_q.push_back({1'b1, b}); m_rem--; end
    else if (m_len) begin exp_q.push_back({1'b0, b}); m_len = 1'b0; m_rem = (b == 0) ? 1 : int'(b); end
    else begin exp_q.push_back({1'b0, b}); m_len = (b == LEN_OP); end
  endtask

  task automatic send3(input logic [7:0] b); send_raw(b, 1'b0); model3(b); endtask
  task automatic sendp(input logic [7:0] b, input logic d);
    send_raw(b, d); exp_q.push_back({d, b});
  endtask

  task automatic compare(input string tag);
    wclk(8);
    check({tag, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) check(tag, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  task automatic do_read(input string tag);
    for (int i = 7; i >= 0; i--) begin
      wclk(HP);
      check({tag, " oe"}, sdo_oe, 1'b1);
      check({tag, " bit"}, sdo_out, status[i]);
      sclk = 1'b1; wclk(HP); sclk = 1'b0;
    end
    wclk(HP);
    check({tag, " oe off"}, sdo_oe, 1'b0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    wclk(4);
    check("R10 reset valid", byte_valid, 1'b0);
    check("R10 reset oe", sdo_oe, 1'b0);
    rst = 1'b0; wclk(4);

    // R4 directed and random, four-wire SPI
    mode_sel = 2'b01; cs_lo();
    sendp(8'hA5, 1'b1); sendp(8'h00, 1'b0); sendp(8'hFF, 1'b1);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] b; logic d;
      b = 8'($urandom); d = 1'($urandom);
      if (!d && b == RD_OP) b = b ^ 8'h01;
      sendp(b, d);
    end
    cs_hi(); compare("R4 spi4");

    // R5 nine-bit frames back to back
    mode_sel = 2'b11; cs_lo();
    sendp(8'h81, 1'b1); sendp(8'h7E, 1'b0);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] b; logic d;
      b = 8'($urandom); d = 1'($urandom);
      if (!d && b == RD_OP) b = b ^ 8'h01;
      sendp(b, d);
    end
    cs_hi(); compare("R5 ser9");

    // R6 and R7 three-wire SPI length rule, data byte equal to RD_OP stays data
    mode_sel = 2'b00; m_len = 0; m_rem = 0; cs_lo();
    send3(8'h11); send3(LEN_OP); send3(8'd3); send3(RD_OP); send3(8'h22); send3(LEN_OP);
    send3(8'h44); send3(8'h55);
    send3(LEN_OP); send3(8'd0); send3(8'h66); send3(8'h77);
    for (int k = 0; k < 8; k++) begin
      int len; logic [7:0] c;
      len = int'($urandom % 6);
      send3(LEN_OP); send3(8'(len));
      for (int j = 0; j < ((len == 0) ? 1 : len); j++) send3(8'($urandom));
      c = 8'($urandom);
      if (c == LEN_OP || c == RD_OP) c = 8'h01;
      send3(c);
    end
    cs_hi(); compare("R6 R7 spi3");

    // R8 abort mid-byte with pending length
    cs_lo(); send3(LEN_OP); send3(8'd4); send3(8'h91);
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    cs_hi(); m_len = 0; m_rem = 0;
    cs_lo(); send3(8'h92); cs_hi();
    compare("R8 abort");

    // R8 chip enable rising in the same sample as the final edge
    cs_lo(); send3(LEN_OP); send3(8'd2);
    for (int i = 7; i >= 1; i--) bit_out(1'b0);
    sdin = 1'b1; wclk(HP); sclk = 1'b1; csn = 1'b1; wclk(HP); sclk = 1'b0; wclk(2 * HP);
    m_len = 0; m_rem = 0;
    cs_lo(); send3(8'hC3); cs_hi();
    compare("R8 coincident");

    // R2 clocks with chip enable high are ignored
    for (int i = 0; i < 12; i++) bit_out(1'b1);
    wclk(8);
    check("R2 cs high strobes", got_q.size(), 0);
    cs_lo(); send3(8'h5A); cs_hi(); compare("R2 fresh byte");

    // R9 read-back in three modes
    status = 8'hB6;
    cs_lo(); send3(RD_OP);
    do_read("R9 spi3");
    send3(8'h12); cs_hi(); compare("R9 spi3 after");
    mode_sel = 2'b01; status = 8'h4D;
    cs_lo(); sendp(RD_OP, 1'b0); do_read("R9 spi4"); cs_hi(); compare("R9 spi4 rx");
    mode_sel = 2'b11; status = 8'hE1;
    cs_lo(); sendp(RD_OP, 1'b0); do_read("R9 ser9"); sendp(8'h33, 1'b1); cs_hi();
    compare("R9 ser9 after");

    // R1 bus-reserved code
    mode_sel = 2'b10;
    cs_lo(); send_raw(RD_OP, 1'b0); send_raw(8'hAA, 1'b1);
    check("R1 oe", sdo_oe, 1'b0);
    cs_hi(); wclk(8);
    check("R1 strobes", got_q.size(), 0);
    got_q.delete();

    // R10 reset during a byte, then new byte right after
    mode_sel = 2'b01; cs_lo();
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    rst = 1'b1; wclk(3); rst = 1'b0; wclk(4);
    sendp(8'h81, 1'b1); cs_hi();
    compare("R10 after reset");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule